// File: doc/BRIEF.md
# Fixed-Point Lattice-Ladder IIR Filter

This block is a sample-serial recursive filter. A lattice of reflection stages feeds a ladder of tap weights. Samples, coefficients and internal state are all signed 16-bit words in 1.15 fractional format.

A sample is taken on a valid/ready handshake. The block then walks the stage chain, one stage per clock, using one reflection multiply pair and one ladder multiply per cycle. It then presents a single output word, which is held until the consumer takes it. Only one sample is ever in flight.

The number of active stages is chosen per sample, from zero up to a synthesis-time maximum. Reflection and ladder coefficients are loaded through a small write port while the filter is idle. The delay-line state lives inside the block and starts from zero after reset.

Top module: `lattice_iir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_sample` is 0 and `cw_err` is 0. All coefficients and all state words are zero, so the first sample after any reset sees a cleared delay line.
- R2: For stages s = 0 .. N-1 in order, with forward value f (equal to the input sample at s = 0), stored word g = state[s] and reflection coefficient k[s], the block computes two values, each clipped to the range [-32768, 32767]. The new forward value is f' = clip(f - ((g*k[s]) >>> 15)). The new backward value is b = clip(((f'*k[s]) >>> 15) + g).
- R3: Each stage's b times ladder coefficient v[s] is summed at full product precision in an accumulator at least 64 bits wide. The final forward value times v[N] is then added. The output is clip(sum >>> 15), so intermediate sums never wrap.
- R4: After a sample with N > 0 stages, state[s-1] takes the b of stage s for s = 1 .. N-1, and state[N-1] takes the final forward value. The b of stage 0 is discarded. State words at index N and above are untouched.
- R5: The stage count N is taken from `stage_cnt` on the accepting clock edge. Changes to `stage_cnt` while the sample is being processed have no effect. Values above `MAX_STAGES` are treated as `MAX_STAGES`.
- R6: With N = 0 the output is clip((x*v[0]) >>> 15) and no state word changes.
- R7: `out_valid` rises on the (N+1)-th rising edge after the accepting edge. `in_ready` stays low from the accepting edge until the output is handed off.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_sample` stay unchanged. After the edge where both are 1, `out_valid` is 0 and `in_ready` is 1.
- R9: A write with `cw_en` = 1 while `in_ready` is 1 stores `cw_data`. `cw_ladder` = 0 selects reflection coefficient k[`cw_addr`] (addresses 0 .. MAX_STAGES-1). `cw_ladder` = 1 selects ladder coefficient v[`cw_addr`] (addresses 0 .. MAX_STAGES). The new value is used from the next accepted sample on.
- R10: A write attempted while `in_ready` is 0 leaves every coefficient unchanged. It sets `cw_err` to 1, and `cw_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_sample | input | 16 | Input sample, 1.15 signed |
| stage_cnt | input | $clog2(MAX_STAGES+1) | Active stage count for the sample being accepted |
| out_valid | output | 1 | Output sample presented |
| out_ready | input | 1 | Consumer takes the output |
| out_sample | output | 16 | Filtered sample, 1.15 signed |
| cw_en | input | 1 | Coefficient write strobe |
| cw_ladder | input | 1 | 0 = reflection bank, 1 = ladder bank |
| cw_addr | input | $clog2(MAX_STAGES+1) | Coefficient index |
| cw_data | input | 16 | Coefficient value, 1.15 signed |
| cw_err | output | 1 | Sticky flag: a write was attempted while busy |

## Verification
The bench sweeps every stage count from zero to one past the maximum, across three coefficient sets that include full-scale negative reflections and full-scale ladder weights. A stage that skipped its saturation, or an accumulator narrower than the ladder sum needs, would give outputs wrapped to the wrong sign. A design that kept the stage-0 backward value instead of discarding it, or that disturbed state beyond index N-1, would drift from the reference on the samples that follow. Zero-stage samples placed between longer ones catch a design that writes state when it should not. Writes and stage-count changes injected mid-sample show whether the design leaks them into the current or next result. Output holds of varying length check that the output word stays still until it is taken.

// File: rtl/lattice_iir_pkg.sv
package lattice_iir_pkg;
    localparam int DATA_W = 16;
    localparam int FRAC_W = DATA_W - 1;
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = 64;

    typedef logic signed [DATA_W-1:0] word_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_t;

    // outputs of one reflection stage
    typedef struct packed {
        word_t fwd;
        word_t bwd;
    } node_t;

    function automatic acc_t widen(input word_t a);
        return acc_t'(a);
    endfunction

    // fractional product, low FRAC_W bits dropped (arithmetic shift)
    function automatic acc_t qmul(input word_t a, input word_t b);
        prod_t p;
        p = prod_t'(a) * prod_t'(b);
        return acc_t'(p) >>> FRAC_W;
    endfunction

    function automatic word_t clip(input acc_t x);
        acc_t hi;
        acc_t lo;
        hi = (acc_t'(1) <<< FRAC_W) - acc_t'(1);
        lo = -(acc_t'(1) <<< FRAC_W);
        if (x > hi)
            return hi[DATA_W-1:0];
        else if (x < lo)
            return lo[DATA_W-1:0];
        else
            return x[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/lat_stage_math.sv
module lat_stage_math
    import lattice_iir_pkg::*;
(
    input  word_t f_in,
    input  word_t g_old,
    input  word_t refl,
    output node_t res
);
    word_t f_new;

    always_comb begin
        f_new   = clip(widen(f_in) - qmul(g_old, refl));
        res.fwd = f_new;
        res.bwd = clip(qmul(f_new, refl) + widen(g_old));
    end
endmodule

// File: rtl/lat_coef_bank.sv
module lat_coef_bank
    import lattice_iir_pkg::*;
#(
    parameter int MAX_STAGES = 4,
    parameter int IDXW       = $clog2(MAX_STAGES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_ladder,
    input  logic [IDXW-1:0] wr_addr,
    input  word_t           wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output word_t           refl_q,
    output word_t           ladder_q
);
    localparam int AW = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1;
    localparam logic [IDXW-1:0] MAX_IDX = IDXW'(MAX_STAGES);

    word_t refl_r [MAX_STAGES];
    word_t lad_r  [MAX_STAGES+1];
    logic [MAX_STAGES-1:0] refl_hit;
    logic [MAX_STAGES:0]   lad_hit;

    genvar gi;
    generate
        for (gi = 0; gi < MAX_STAGES; gi++) begin : g_refl_hit
            assign refl_hit[gi] = wr_en && !wr_ladder && (wr_addr == IDXW'(gi));
        end
        for (gi = 0; gi <= MAX_STAGES; gi++) begin : g_lad_hit
            assign lad_hit[gi] = wr_en && wr_ladder && (wr_addr == IDXW'(gi));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_STAGES; i++) begin
            if (rst)
                refl_r[i] <= '0;
            else if (refl_hit[i])
                refl_r[i] <= wr_data;
        end
        for (int i = 0; i <= MAX_STAGES; i++) begin
            if (rst)
                lad_r[i] <= '0;
            else if (lad_hit[i])
                lad_r[i] <= wr_data;
        end
    end

    assign refl_q   = (rd_idx < MAX_IDX)  ? refl_r[rd_idx[AW-1:0]] : '0;
    assign ladder_q = (rd_idx <= MAX_IDX) ? lad_r[rd_idx] : '0;
endmodule

// File: rtl/lat_state_file.sv
module lat_state_file
    import lattice_iir_pkg::*;
#(
    parameter int MAX_STAGES = 4,
    parameter int IDXW       = $clog2(MAX_STAGES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  word_t           wdata,
    input  logic [IDXW-1:0] raddr,
    output word_t           rdata
);
    localparam int AW = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1;
    localparam logic [IDXW-1:0] MAX_IDX = IDXW'(MAX_STAGES);

    word_t mem [MAX_STAGES];
    logic [MAX_STAGES-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < MAX_STAGES; gi++) begin : g_hit
            assign hit[gi] = we && (waddr == IDXW'(gi));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_STAGES; i++) begin
            if (rst)
                mem[i] <= '0;
            else if (hit[i])
                mem[i] <= wdata;
        end
    end

    assign rdata = (raddr < MAX_IDX) ? mem[raddr[AW-1:0]] : '0;
endmodule

// File: rtl/lattice_iir.sv
module lattice_iir
    import lattice_iir_pkg::*;
#(
    parameter int MAX_STAGES = 4,
    localparam int IDXW      = $clog2(MAX_STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [IDXW-1:0]   stage_cnt,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_sample,
    input  logic              cw_en,
    input  logic              cw_ladder,
    input  logic [IDXW-1:0]   cw_addr,
    input  logic [DATA_W-1:0] cw_data,
    output logic              cw_err
);
    localparam logic [IDXW-1:0] MAX_IDX = IDXW'(MAX_STAGES);

    phase_t          ph;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] nst;
    word_t           f_q;
    word_t           out_q;
    acc_t            acc_q;
    logic            err_q;

    word_t           refl_sel;
    word_t           lad_sel;
    word_t           st_rd;
    node_t           node;
    logic            run_stage;
    logic            run_final;
    logic            st_we;
    logic [IDXW-1:0] st_wa;
    word_t           st_wd;
    word_t           lad_op;
    prod_t           lad_prod;
    acc_t            acc_sum;
    logic            coef_we;

    assign in_ready   = (ph == PH_IDLE);
    assign out_valid  = (ph == PH_HOLD);
    assign out_sample = out_q;
    assign cw_err     = err_q;
    assign coef_we    = cw_en && (ph == PH_IDLE);

    assign run_stage = (ph == PH_RUN) && (idx != nst);
    assign run_final = (ph == PH_RUN) && (idx == nst);

    lat_coef_bank #(.MAX_STAGES(MAX_STAGES), .IDXW(IDXW)) u_coef (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (coef_we),
        .wr_ladder(cw_ladder),
        .wr_addr  (cw_addr),
        .wr_data  (cw_data),
        .rd_idx   (idx),
        .refl_q   (refl_sel),
        .ladder_q (lad_sel)
    );

    lat_state_file #(.MAX_STAGES(MAX_STAGES), .IDXW(IDXW)) u_state (
        .clk  (clk),
        .rst  (rst),
        .we   (st_we),
        .waddr(st_wa),
        .wdata(st_wd),
        .raddr(idx),
        .rdata(st_rd)
    );

    lat_stage_math u_stage (
        .f_in (f_q),
        .g_old(st_rd),
        .refl (refl_sel),
        .res  (node)
    );

    // stage s writes slot s-1; the closing step writes slot N-1 (= idx-1)
    assign st_we = (run_stage && (idx != '0)) || (run_final && (nst != '0));
    assign st_wa = idx - IDXW'(1);
    assign st_wd = run_final ? f_q : node.bwd;

    assign lad_op   = run_final ? f_q : node.bwd;
    assign lad_prod = prod_t'(lad_op) * prod_t'(lad_sel);
    assign acc_sum  = acc_q + acc_t'(lad_prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            idx   <= '0;
            nst   <= '0;
            f_q   <= '0;
            acc_q <= '0;
            out_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (cw_en && (ph != PH_IDLE))
                err_q <= 1'b1;
            unique case (ph)
                PH_IDLE: begin
                    if (in_valid) begin
                        f_q   <= in_sample;
                        acc_q <= '0;
                        idx   <= '0;
                        nst   <= (stage_cnt > MAX_IDX) ? MAX_IDX : stage_cnt;
                        ph    <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (run_stage) begin
                        f_q   <= node.fwd;
                        acc_q <= acc_sum;
                        idx   <= idx + IDXW'(1);
                    end else begin
                        out_q <= clip(acc_sum >>> FRAC_W);
                        ph    <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (out_ready)
                        ph <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lattice_iir_chk.sv
module lattice_iir_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_sample,
    input logic        cw_en,
    input logic        cw_err
);
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_one_in_flight_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

    p_handoff_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    p_busy_write_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (cw_en && !in_ready) |=> cw_err);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        cw_err |=> cw_err);
endmodule

bind lattice_iir lattice_iir_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sample(out_sample),
    .cw_en     (cw_en),
    .cw_err    (cw_err)
);

// File: tb/lattice_iir_tb.sv
module lattice_iir_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 4;
    localparam int IDXW       = $clog2(MAXS + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [15:0]     in_sample = '0;
    logic [IDXW-1:0] stage_cnt = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [15:0]     out_sample;
    logic            cw_en = 1'b0;
    logic            cw_ladder = 1'b0;
    logic [IDXW-1:0] cw_addr = '0;
    logic [15:0]     cw_data = '0;
    logic            cw_err;

    int checks   = 0;
    int failures = 0;

    longint ms [MAXS];
    longint mk [MAXS];
    longint mv [MAXS+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    lattice_iir #(.MAX_STAGES(MAXS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .stage_cnt(stage_cnt), .out_valid(out_valid),
        .out_ready(out_ready), .out_sample(out_sample), .cw_en(cw_en),
        .cw_ladder(cw_ladder), .cw_addr(cw_addr), .cw_data(cw_data), .cw_err(cw_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint model_step(input longint x, input int n);
        longint f, g, fn, gn, acc;
        acc = 0;
        f = x;
        for (int i = 0; i < n; i++) begin
            g  = ms[i];
            fn = sat16(f - ((g * mk[i]) >>> 15));
            gn = sat16(((fn * mk[i]) >>> 15) + g);
            acc += gn * mv[i];
            if (i > 0) ms[i-1] = gn;
            f = fn;
        end
        acc += f * mv[n];
        if (n > 0) ms[n-1] = f;
        return sat16(acc >>> 15);
    endfunction

    function automatic int pat(input int a);
        return ((a * 20011 + 7) % 65536) - 32768;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < MAXS; i++) begin ms[i] = 0; mk[i] = 0; end
        for (int i = 0; i <= MAXS; i++) mv[i] = 0;
    endfunction

    task automatic write_coef(input bit lad, input int a, input longint d);
        @(negedge clk);
        cw_en = 1'b1; cw_ladder = lad; cw_addr = IDXW'(a); cw_data = 16'(d);
        @(negedge clk);
        cw_en = 1'b0;
        if (lad) mv[a] = d; else mk[a] = d;
    endtask

    task automatic load_set(input int s);
        longint kv, vv;
        for (int i = 0; i <= MAXS; i++) begin
            case (s)
                0: begin kv = pat(i*3+1) / 2; vv = pat(i*5+2); end
                1: begin kv = -32768; vv = 32767; end
                default: begin
                    kv = (i % 2 == 0) ? 32767 : -32767;
                    vv = (i % 2 == 0) ? -32768 : 12000;
                end
            endcase
            if (i < MAXS) write_coef(1'b0, i, kv);
            write_coef(1'b1, i, vv);
        end
    endtask

    // poke: during processing, attempt a ladder write and change stage_cnt
    task automatic do_sample(input longint x, input int ncfg, input int hold, input bit poke);
        int neff, lat;
        longint exp_y;
        neff  = (ncfg > MAXS) ? MAXS : ncfg;
        exp_y = model_step(x, neff);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(x); stage_cnt = IDXW'(ncfg);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        if (poke) begin
            cw_en = 1'b1; cw_ladder = 1'b1; cw_addr = '0; cw_data = 16'h4000;
            stage_cnt = '0;
        end
        while (!out_valid && lat < 40) begin
            check(in_ready == 1'b0, "R7 in_ready low while busy", longint'(in_ready), 0);
            @(negedge clk);
            cw_en = 1'b0;
            lat++;
        end
        if (poke)
            check(cw_err == 1'b1, "R10 busy write flags error", longint'(cw_err), 1);
        check(lat == neff + 1, "R7/R5 latency", lat, neff + 1);
        check(longint'($signed(out_sample)) == exp_y, "R2/R3/R4 output value",
              longint'($signed(out_sample)), exp_y);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(out_valid && longint'($signed(out_sample)) == exp_y, "R8 output held",
                  longint'($signed(out_sample)), exp_y);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(in_ready && !out_valid, "R8 handoff returns to idle",
              longint'({in_ready, out_valid}), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
        check(out_sample == 16'h0, "R1 out_sample after reset", longint'(out_sample), 0);
        check(cw_err == 1'b0, "R1 cw_err after reset", longint'(cw_err), 0);

        // all coefficients zero after reset: output zero (R1)
        do_sample(32767, MAXS, 0, 1'b0);

        // sweep coefficient sets x stage counts (incl. one past max, R5) x inputs
        for (int s = 0; s < 3; s++) begin
            load_set(s);   // R9: new coefficients take effect for the next sample
            for (int n = 0; n <= MAXS + 1; n++) begin
                for (int j = 0; j < 6; j++) begin
                    longint x;
                    x = (j == 0) ? 32767 : (j == 1) ? -32768 : pat(j*11 + s + n);
                    do_sample(x, n, j % 3, 1'b0);
                end
                // R6: a zero-stage sample between longer ones keeps the state
                do_sample(pat(n + 50), 0, 0, 1'b0);
            end
        end

        // R10/R5: write and stage change while busy are ignored
        load_set(0);
        do_sample(12345, 3, 1, 1'b1);
        do_sample(-2222, 3, 0, 1'b0);
        do_sample(30000, MAXS, 0, 1'b0);
        check(cw_err == 1'b1, "R10 error stays set", longint'(cw_err), 1);

        // R9: write at index MAXS of ladder bank affects the closing term
        write_coef(1'b1, MAXS, -20000);
        do_sample(25000, MAXS, 0, 1'b0);

        // R1: reset clears state, coefficients and error flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        @(negedge clk);
        check(cw_err == 1'b0, "R1 cw_err cleared by reset", longint'(cw_err), 0);
        load_set(2);
        do_sample(-30000, MAXS, 0, 1'b0);
        do_sample(17, 2, 0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule